// File: doc/BRIEF.md
# Serial-bus byte memory slave front end

This block is the serial front end of a small byte-addressed nonvolatile memory model. A host drives a four-wire serial bus: clock, data in, active-low select and an active-low pause line. The block oversamples these pins on its own system clock. It shifts in an 8-bit command and, where the command needs one, a 16-bit address and then data bytes. It returns read data or the status byte on a serial output that carries a separate drive enable.

Write data goes to a page store that keeps every burst inside one 16-byte page. Status updates and the write-enable latch are handled by a separate guard unit. The guard decides whether each byte may land in the array. A read keeps streaming bytes from consecutive addresses for as long as the host keeps clocking. The host can pause any transfer by pulling the pause line low and continue it later from the bit where it stopped.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable is low and the status byte reads 0x00: the enable latch is clear and both protection bits are zero.
- R2: Input bits are taken on rising serial-clock edges, most significant bit first. Both clock polarities work: idle low (mode 0) and idle high (mode 3).
- R3: Command 0x06 sets the enable latch (status bit 1). Command 0x04 clears it.
- R4: Command 0x05 streams the status byte, repeated for as long as clocks arrive. Bits 3:2 hold the protection level, bit 1 holds the enable latch, and all other bits are 0.
- R5: Command 0x02, then a 16-bit address, then data bytes: each complete byte is stored when the latch is set. The address advances within its 16-byte page, so the low 4 bits wrap and the upper bits stay. When select rises after at least one complete byte, the latch clears.
- R6: A write command issued while the latch is clear leaves the array unchanged.
- R7: Command 0x03, then a 16-bit address, returns data most significant bit first. Only the low 10 address bits are used. Each output bit changes after a falling clock edge. Reading continues through consecutive bytes and wraps from 0x3FF to 0x000.
- R8: Command 0x01, then one byte, loads byte bits 3:2 into the protection level when the latch is set, and the latch clears when select rises. When the latch is clear the command is ignored.
- R9: Protection level 0 protects nothing, 1 protects the top quarter (0x300-0x3FF), 2 protects the top half (0x200-0x3FF) and 3 protects everything. Writes to protected bytes are dropped, and the latch still clears afterwards.
- R10: While the pause line is low, clock and data edges are ignored and the output enable is low. When the line returns high, the transfer continues from the same bit.
- R11: Raising select ends any transaction, even during a pause. The output enable is low whenever the block is not sending read or status data.
- R12: An undefined command byte causes every later bit to be ignored until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus pins |
| rst_n | input | 1 | Active-low reset (power-up) |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for so; low means high impedance |

## Verification
Single bytes go to scattered addresses and are read back with the other clock polarity. This separates correct bit ordering and address masking from faults that depend on polarity. A three-byte burst that crosses a page end tells page wrap apart from a plain linear increment. A read across the top address tells wrap to zero apart from running off the end. Writes with the latch clear, and writes into each protection level, show whether the guard blocks them while still clearing the latch. A pause in the middle of a byte, with clock toggling during it, shows whether the bit position survives the pause. Raising select during a pause shows whether the transaction ends.

// File: rtl/see_pkg.sv
package see_pkg;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_SRIN, PH_SROUT, PH_SKIP
    } phase_t;

    typedef struct packed {
        phase_t      phase;
        logic [3:0]  cnt;
        logic [15:0] sh;
        logic [7:0]  op;
        logic [15:0] addr;
        logic [2:0]  obit;
        logic        started;
        logic        done;
        logic        so;
    } eng_t;

    typedef struct packed {
        logic       wel;
        logic [1:0] bp;
    } guard_t;
endpackage

// File: rtl/see_pin_sync.sv
module see_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    output logic si_s,
    output logic sel,
    output logic held,
    output logic sck_rise,
    output logic sck_fall
);
    // bit order in each stage: {cs_n, hold_n, sck, si}
    localparam logic [3:0] IDLE_PINS = 4'b1100;

    logic [3:0] stage_q [STAGES];
    logic       sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= IDLE_PINS;
        else        stage_q[0] <= {cs_n, hold_n, sck, si};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= IDLE_PINS;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    logic sck_s;
    assign sel   = ~stage_q[STAGES-1][3];
    assign held  = ~stage_q[STAGES-1][2];
    assign sck_s = stage_q[STAGES-1][1];
    assign si_s  = stage_q[STAGES-1][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_prev_q & sel & ~held;
    assign sck_fall = ~sck_s & sck_prev_q & sel & ~held;
endmodule

// File: rtl/see_cmd_engine.sv
module see_cmd_engine
    import see_pkg::*;
#(
    parameter int AW   = 10,
    parameter int PAGE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          si,
    input  logic [7:0]    rd_byte,
    input  logic [7:0]    status,
    output logic [AW-1:0] rd_addr,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sr_req,
    output logic [1:0]    sr_bp,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          so,
    output logic          driving
);
    localparam logic [15:0] PMASK = 16'(PAGE - 1);

    eng_t q, d;
    logic [15:0] shifted;
    logic [7:0]  out_byte;

    assign shifted  = {q.sh[14:0], si};
    assign out_byte = (q.phase == PH_RDATA) ? rd_byte : status;

    always_comb begin
        d       = q;
        wr_req  = 1'b0;
        sr_req  = 1'b0;
        wel_set = 1'b0;
        wel_clr = 1'b0;
        if (!sel) begin
            d.phase   = PH_CMD;
            d.cnt     = '0;
            d.obit    = '0;
            d.started = 1'b0;
            d.done    = 1'b0;
            wel_clr   = q.done;
        end else if (sck_rise) begin
            d.sh  = shifted;
            d.cnt = q.cnt + 4'd1;
            case (q.phase)
                PH_CMD: begin
                    if (q.cnt == 4'd7) begin
                        d.cnt = '0;
                        d.op  = shifted[7:0];
                        case (shifted[7:0])
                            OP_WRSR:  d.phase = PH_SRIN;
                            OP_WRITE: d.phase = PH_ADDR;
                            OP_READ:  d.phase = PH_ADDR;
                            OP_RDSR:  d.phase = PH_SROUT;
                            OP_WREN: begin
                                wel_set = 1'b1;
                                d.phase = PH_SKIP;
                            end
                            OP_WRDI: begin
                                wel_clr = 1'b1;
                                d.phase = PH_SKIP;
                            end
                            default:  d.phase = PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR: begin
                    if (q.cnt == 4'd15) begin
                        d.cnt   = '0;
                        d.addr  = shifted;
                        d.phase = (q.op == OP_READ) ? PH_RDATA : PH_WDATA;
                    end
                end
                PH_WDATA: begin
                    if (q.cnt == 4'd7) begin
                        d.cnt  = '0;
                        wr_req = 1'b1;
                        d.done = 1'b1;
                        d.addr = (q.addr & ~PMASK) | ((q.addr + 16'd1) & PMASK);
                    end
                end
                PH_SRIN: begin
                    if (q.cnt == 4'd7) begin
                        d.cnt   = '0;
                        sr_req  = 1'b1;
                        d.done  = 1'b1;
                        d.phase = PH_SKIP;
                    end
                end
                default: ;
            endcase
        end else if (sck_fall && (q.phase == PH_RDATA || q.phase == PH_SROUT)) begin
            d.so      = out_byte[3'd7 - q.obit];
            d.started = 1'b1;
            d.obit    = q.obit + 3'd1;
            if (q.obit == 3'd7 && q.phase == PH_RDATA) d.addr = q.addr + 16'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_CMD, cnt: '0, sh: '0, op: '0, addr: '0,
                   obit: '0, started: 1'b0, done: 1'b0, so: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr[AW-1:0];
    assign wr_addr = q.addr[AW-1:0];
    assign wr_data = shifted[7:0];
    assign sr_bp   = shifted[3:2];
    assign so      = q.so;
    assign driving = q.started;
endmodule

// File: rtl/see_wr_guard.sv
module see_wr_guard
    import see_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       sr_req,
    input  logic [1:0] sr_bp,
    input  logic       wr_req,
    input  logic [1:0] wr_blk,
    output logic       wr_grant,
    output logic [7:0] status,
    output logic       wel,
    output logic [1:0] bp
);
    guard_t q, d;
    logic   locked;

    always_comb begin
        d = q;
        if (wel_set) d.wel = 1'b1;
        if (wel_clr) d.wel = 1'b0;
        if (sr_req && q.wel) d.bp = sr_bp;
    end

    always_comb begin
        case (q.bp)
            2'd0:    locked = 1'b0;
            2'd1:    locked = (wr_blk == 2'b11);
            2'd2:    locked = wr_blk[1];
            default: locked = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{wel: 1'b0, bp: 2'b00};
        else        q <= d;
    end

    assign wr_grant = wr_req & q.wel & ~locked;
    assign status   = {4'b0000, q.bp, q.wel, 1'b0};
    assign wel      = q.wel;
    assign bp       = q.bp;
endmodule

// File: rtl/see_page_store.sv
module see_page_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int DEPTH       = 1024,
    parameter int PAGE        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int AW = $clog2(DEPTH);

    logic          si_s, sel, held, sck_rise, sck_fall;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0]    rd_byte, wr_data, status;
    logic          wr_req, wr_grant, sr_req, wel_set, wel_clr, driving, wel;
    logic [1:0]    sr_bp, bp;

    see_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
        .si_s(si_s), .sel(sel), .held(held), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    see_cmd_engine #(.AW(AW), .PAGE(PAGE)) u_eng (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .si(si_s), .rd_byte(rd_byte), .status(status), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .sr_req(sr_req),
        .sr_bp(sr_bp), .wel_set(wel_set), .wel_clr(wel_clr), .so(so), .driving(driving)
    );

    see_wr_guard u_guard (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .sr_req(sr_req), .sr_bp(sr_bp), .wr_req(wr_req), .wr_blk(wr_addr[AW-1:AW-2]),
        .wr_grant(wr_grant), .status(status), .wel(wel), .bp(bp)
    );

    see_page_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(wr_grant), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_byte)
    );

    assign so_oe = driving & sel & ~held;
endmodule

// File: rtl/see_checker.sv
module see_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       hold_n,
    input logic       so,
    input logic       so_oe,
    input logic       sck_fall,
    input logic       wel,
    input logic [1:0] bp
);
    assert_oe_released_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

    assert_oe_released_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe);

    assert_so_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(sck_fall));

    assert_bp_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $past(wel));
endmodule

bind spi_eeprom_slave see_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so(so), .so_oe(so_oe),
    .sck_fall(sck_fall), .wel(wel), .bp(bp)
);

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;
    localparam int HPT        = HP * CLK_PERIOD;

    // {write mode, write address, read address, data}; read uses the other mode
    localparam logic [40:0] VEC [6] = '{
        {1'b0, 16'h0040, 16'h0040, 8'h5A},
        {1'b1, 16'h0081, 16'h0081, 8'hC3},
        {1'b0, 16'hFC05, 16'h0005, 8'h3C},
        {1'b1, 16'h0123, 16'h0123, 8'h01},
        {1'b0, 16'h0200, 16'h0200, 8'hFF},
        {1'b1, 16'h7155, 16'h0155, 8'h80}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
    logic so, so_oe;
    logic mode3 = 1'b0;
    int   checks = 0;
    int   fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic m);
        mode3 = m;
        sck   = m;
        #(HPT);
    endtask

    task automatic sel_lo;
        cs_n = 1'b0;
        #(HPT);
    endtask

    task automatic sel_hi;
        #(HPT);
        cs_n = 1'b1;
        #(3*HPT);
    endtask

    task automatic bit_x(input logic b, output logic r);
        if (mode3) begin
            sck = 1'b0; si = b; #(HPT);
            sck = 1'b1; r = so; #(HPT);
        end else begin
            si = b; #(HPT);
            sck = 1'b1; r = so; #(HPT);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            bit_x(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] dummy;
        sel_lo; xfer(op, dummy); sel_hi;
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] dummy;
        sel_lo; xfer(8'h05, dummy); xfer(8'h00, s); sel_hi;
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] dummy;
        sel_lo; xfer(8'h01, dummy); xfer(v, dummy); sel_hi;
    endtask

    task automatic write1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] dummy;
        sel_lo; xfer(8'h02, dummy); xfer(a[15:8], dummy); xfer(a[7:0], dummy);
        xfer(v, dummy); sel_hi;
    endtask

    task automatic read1(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] dummy;
        sel_lo; xfer(8'h03, dummy); xfer(a[15:8], dummy); xfer(a[7:0], dummy);
        xfer(8'h00, v); sel_hi;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        fails++;
        checks++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] s, d, d2, dummy;
        logic       r;
        repeat (5) @(negedge clk);
        check8("R1 oe in reset", {7'd0, so_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        set_mode(1'b0);
        check8("R1 oe after reset", {7'd0, so_oe}, 8'h00);
        rdsr(s);  check8("R1 status after reset", s, 8'h00);

        cmd1(8'h06); rdsr(s); check8("R3 enable sets bit1", s, 8'h02);
        cmd1(8'h04); rdsr(s); check8("R3 disable clears bit1", s, 8'h00);

        // vector table: write in one polarity, read back in the other
        for (int i = 0; i < 6; i++) begin
            logic [40:0] v;
            v = VEC[i];
            set_mode(v[40]);
            cmd1(8'h06);
            write1(v[39:24], v[7:0]);
            set_mode(!v[40]);
            read1(v[23:8], d);
            check8($sformatf("R2 R5 R7 vector %0d", i), d, v[7:0]);
        end

        // page wrap burst: 0x1E, 0x1F, then back to 0x10
        set_mode(1'b0);
        cmd1(8'h06);
        sel_lo; xfer(8'h02, dummy); xfer(8'h00, dummy); xfer(8'h1E, dummy);
        xfer(8'hA1, dummy); xfer(8'hA2, dummy); xfer(8'hA3, dummy); sel_hi;
        read1(16'h0010, d); check8("R5 page wrap to 0x10", d, 8'hA3);
        sel_lo; xfer(8'h03, dummy); xfer(8'h00, dummy); xfer(8'h1E, dummy);
        xfer(8'h00, d); xfer(8'h00, d2); sel_hi;
        check8("R5 burst byte 0", d, 8'hA1);
        check8("R5 burst byte 1", d2, 8'hA2);
        rdsr(s); check8("R5 latch cleared after write", s, 8'h00);

        write1(16'h0010, 8'h55);
        read1(16'h0010, d); check8("R6 write without latch", d, 8'hA3);

        // sequential read wrap at the top
        cmd1(8'h06); write1(16'h03FF, 8'h77);
        cmd1(8'h06); write1(16'h0000, 8'h88);
        sel_lo; xfer(8'h03, dummy); xfer(8'h03, dummy); xfer(8'hFF, dummy);
        xfer(8'h00, d); xfer(8'h00, d2); sel_hi;
        check8("R7 top byte", d, 8'h77);
        check8("R7 wrap to zero", d2, 8'h88);

        // status writes and protection
        cmd1(8'h06); write1(16'h0300, 8'h22);
        cmd1(8'h06); write1(16'h02FF, 8'h33);
        wrsr(8'h04); rdsr(s); check8("R8 status write without latch", s, 8'h00);
        cmd1(8'h06); wrsr(8'h04); rdsr(s); check8("R8 level 1 latched, latch cleared", s, 8'h04);
        sel_lo; xfer(8'h05, dummy); xfer(8'h00, d); xfer(8'h00, d2); sel_hi;
        check8("R4 status first", d, 8'h04);
        check8("R4 status repeated", d2, 8'h04);

        cmd1(8'h06); write1(16'h0300, 8'h11);
        read1(16'h0300, d); check8("R9 top quarter protected", d, 8'h22);
        rdsr(s); check8("R9 latch cleared after blocked write", s, 8'h04);
        cmd1(8'h06); write1(16'h02FF, 8'h44);
        read1(16'h02FF, d); check8("R9 below quarter writable", d, 8'h44);
        cmd1(8'h06); wrsr(8'h08);
        cmd1(8'h06); write1(16'h0200, 8'h66);
        read1(16'h0200, d); check8("R9 top half protected", d, 8'hFF);
        cmd1(8'h06); wrsr(8'h0C);
        cmd1(8'h06); write1(16'h0000, 8'h99);
        read1(16'h0000, d); check8("R9 all protected", d, 8'h88);
        cmd1(8'h06); wrsr(8'h00);
        rdsr(s); check8("R8 level cleared", s, 8'h00);

        // undefined command, then what would be an enable byte
        sel_lo; xfer(8'hAB, dummy); xfer(8'h06, dummy);
        check8("R12 no drive after undefined command", {7'd0, so_oe}, 8'h00);
        sel_hi;
        rdsr(s); check8("R12 following bits ignored", s, 8'h00);

        // pause in the middle of a read byte
        sel_lo; xfer(8'h03, dummy); xfer(8'h00, dummy); xfer(8'h1E, dummy);
        for (int i = 7; i >= 5; i--) begin bit_x(1'b0, r); d[i] = r; end
        check8("R10 driving before pause", {7'd0, so_oe}, 8'h01);
        #(HPT);
        hold_n = 1'b0;
        #(HPT);
        sck = 1'b1; si = 1'b1; #(HPT);
        sck = 1'b0; si = 1'b0; #(HPT);
        check8("R10 released during pause", {7'd0, so_oe}, 8'h00);
        hold_n = 1'b1;
        #(HPT);
        for (int i = 4; i >= 0; i--) begin bit_x(1'b0, r); d[i] = r; end
        sel_hi;
        check8("R10 byte intact across pause", d, 8'hA1);

        // select rises during a pause
        sel_lo; xfer(8'h03, dummy); xfer(8'h00, dummy); xfer(8'h1E, dummy);
        bit_x(1'b0, r); bit_x(1'b0, r);
        #(HPT);
        hold_n = 1'b0;
        #(HPT);
        cs_n = 1'b1;
        #(2*HPT);
        check8("R11 released, select high in pause", {7'd0, so_oe}, 8'h00);
        hold_n = 1'b1;
        #(2*HPT);
        check8("R11 stays released after pause", {7'd0, so_oe}, 8'h00);
        rdsr(s); check8("R11 fresh transaction", s, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule